// File: doc/BRIEF.md
# GPIO Controller with Line Interrupts

This block drives and samples a bank of general-purpose I/O lines from a register bus with APB-style timing. Each line can be made an output or left as an input. Output data, direction and every interrupt setting are changed through paired write-one-to-set and write-one-to-clear registers. Two tasks can therefore update different lines without a read-modify-write sequence.

Every input passes through a two-flop synchronizer into the system clock domain before anything uses it. Each line can raise an interrupt in level mode (active high or active low) or in edge mode (rising, falling, or both edges when the line's both-edges bit is set). Level interrupts follow the synchronized input for as long as the condition lasts. Edge events are latched as pending until software clears them with a write-one. The enabled, active lines appear in a status register and are ORed onto one interrupt output.

Register word index (address bits [5:2]): 0/1 output data set/clear, 2/3 direction set/clear (1 = output), 4/5 mode set/clear (1 = edge), 6/7 polarity set/clear (1 = high or rising), 8/9 both-edges set/clear, 10/11 enable set/clear, 12 pending clear on write and status on read, 13 synchronized input (read only). A read of a set/clear index returns the register it controls. An unused index reads zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Writing ones to the direction-set (index 2) or direction-clear (index 3) register drives the matching `gpio_oe` bits to 1 or to 0. Other bits keep their value.
- R2: Writing ones to output-set (index 0) or output-clear (index 1) sets or clears the matching `gpio_out` bits. `gpio_out` changes on no other cycle.
- R3: The value of `gpio_in` reads back at index 13 two clock edges after it is applied, and not before.
- R4: A line in level mode is active while its synchronized input equals its polarity bit. A write to the clear register (index 12) does not remove it.
- R5: A line in edge mode with its both-edges bit at 0 latches a pending event on a rising synchronized edge when polarity is 1, or on a falling edge when polarity is 0. The event stays until a one is written to its bit at index 12.
- R6: With the both-edges bit set, an edge-mode line latches on either edge, whatever its polarity.
- R7: `irq` is the OR of all lines that are both enabled (index 10/11) and active. With every enable at 0, `irq` stays low even while events are pending, and the pending events return once enables are set again.
- R8: Reading index 12 returns one bit per line that is enabled and active. A disabled line reads 0.
- R9: If an edge is detected in the same cycle as a clear write to that line, the line stays pending.
- R10: After reset all lines are inputs, output data is 0, every line is in level mode with polarity high and both-edges off, all enables are 0, and no event is pending.
- R11: Zero bits in a write to any set or clear register leave the matching bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits [5:2] pick the register |
| pwdata | input | NUM_LINES | Write data, one bit per line |
| prdata | output | NUM_LINES | Read data |
| gpio_in | input | NUM_LINES | Asynchronous line inputs |
| gpio_out | output | NUM_LINES | Output data |
| gpio_oe | output | NUM_LINES | Output enable per line |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle: output data is held when no write occurs, pending bits are kept when no clear is written, the interrupt is masked when all enables are 0, status never shows a disabled line, and the reset state holds. The two-edge input latency, the trigger for each polarity and edge mode, the clear that level lines ignore, and the edge that arrives together with a clear can only be shown by the bench scenarios, which compare every cycle against a behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // Register word indices; set/clear pairs share index>>1
   typedef enum logic [3:0] {
      IDX_OUT_SET  = 4'd0,  IDX_OUT_CLR  = 4'd1,
      IDX_DIR_SET  = 4'd2,  IDX_DIR_CLR  = 4'd3,
      IDX_MODE_SET = 4'd4,  IDX_MODE_CLR = 4'd5,
      IDX_POL_SET  = 4'd6,  IDX_POL_CLR  = 4'd7,
      IDX_BOTH_SET = 4'd8,  IDX_BOTH_CLR = 4'd9,
      IDX_EN_SET   = 4'd10, IDX_EN_CLR   = 4'd11,
      IDX_PEND     = 4'd12, IDX_PIN      = 4'd13
   } reg_idx_e;

   localparam int CFG_REGS = 6;   // out, dir, mode, pol, both, en
   localparam int CFG_POL  = 3;   // the one register that resets to ones
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q_sync,
   output logic [W-1:0] q_dly
);
   if (STAGES < 2) begin : g_bad
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s <= STAGES; s++) st[s] <= '0;
      end else begin
         st[0] <= d;
         for (int s = 1; s <= STAGES; s++) st[s] <= st[s-1];
      end
   end

   assign q_sync = st[STAGES-1];
   assign q_dly  = st[STAGES];
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int W       = 32,
   parameter bit RST_ONE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] RST_VAL = {W{RST_ONE}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RST_VAL;
      else if (set_we) q <= q | wdata;
      else if (clr_we) q <= q & ~wdata;
   end
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_mode,
   input  logic pol_hi,
   input  logic both,
   input  logic en,
   input  logic s_now,
   input  logic s_prev,
   input  logic clr,
   output logic active,
   output logic pend
);
   logic hit;

   always_comb begin
      if (!edge_mode) hit = 1'b0;
      else if (both)  hit = s_now ^ s_prev;
      else if (pol_hi) hit = s_now & ~s_prev;
      else            hit = ~s_now & s_prev;
   end

   // a new edge wins over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= hit | (pend & ~clr);
   end

   assign active = en & (edge_mode ? pend : ~(s_now ^ pol_hi));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES   = 32,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 psel,
   input  logic                 penable,
   input  logic                 pwrite,
   input  logic [ADDR_W-1:0]    paddr,
   input  logic [NUM_LINES-1:0] pwdata,
   output logic [NUM_LINES-1:0] prdata,
   input  logic [NUM_LINES-1:0] gpio_in,
   output logic [NUM_LINES-1:0] gpio_out,
   output logic [NUM_LINES-1:0] gpio_oe,
   output logic                 irq
);
   localparam int IDX_LSB = 2;
   localparam int IDX_MSB = IDX_LSB + 3;

   if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_n
      $error("gpio_irq_ctrl: NUM_LINES must be 1..32");
   end
   if (ADDR_W < IDX_MSB + 1) begin : g_bad_a
      $error("gpio_irq_ctrl: ADDR_W too small for register index");
   end

   logic [3:0]           idx;
   logic                 wr_en;
   logic                 clr_we;
   logic [NUM_LINES-1:0] cfg_q [CFG_REGS];
   logic [NUM_LINES-1:0] s_now, s_prev;
   logic [NUM_LINES-1:0] status, pend_q;

   assign idx    = paddr[IDX_MSB:IDX_LSB];
   assign wr_en  = psel & penable & pwrite;
   assign clr_we = wr_en & (idx == IDX_PEND);

   gpio_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(gpio_in), .q_sync(s_now), .q_dly(s_prev)
   );

   for (genvar g = 0; g < CFG_REGS; g++) begin : g_cfg
      gpio_setclr_reg #(.W(NUM_LINES), .RST_ONE(g == CFG_POL)) u_reg (
         .clk(clk), .rst_n(rst_n),
         .set_we(wr_en & (idx == 4'(2*g))),
         .clr_we(wr_en & (idx == 4'(2*g+1))),
         .wdata(pwdata), .q(cfg_q[g])
      );
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      gpio_irq_line u_line (
         .clk(clk), .rst_n(rst_n),
         .edge_mode(cfg_q[2][i]), .pol_hi(cfg_q[3][i]), .both(cfg_q[4][i]),
         .en(cfg_q[5][i]), .s_now(s_now[i]), .s_prev(s_prev[i]),
         .clr(clr_we & pwdata[i]), .active(status[i]), .pend(pend_q[i])
      );
   end

   always_comb begin
      if (idx < 4'(2*CFG_REGS)) prdata = cfg_q[idx[3:1]];
      else if (idx == IDX_PEND) prdata = status;
      else if (idx == IDX_PIN)  prdata = s_now;
      else                      prdata = '0;
   end

   assign gpio_out = cfg_q[0];
   assign gpio_oe  = cfg_q[1];
   assign irq      = |status;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
   parameter int N = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic         clr_we,
   input logic [N-1:0] pend,
   input logic [N-1:0] en,
   input logic [N-1:0] status,
   input logic [N-1:0] gpio_out,
   input logic [N-1:0] gpio_oe,
   input logic         irq
);
   assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(gpio_out));

   assert_pend_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((pend & $past(pend)) == $past(pend)));

   assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);

   assert_status_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~en) == '0);

   assert_reset_state_R10: assert property (@(posedge clk)
      $rose(rst_n) |-> (gpio_oe == '0 && gpio_out == '0 && pend == '0 && !irq));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr_we(clr_we),
   .pend(pend_q), .en(cfg_q[5]), .status(status),
   .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
   localparam int PERIOD = 10;
   localparam int N = 32;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [N-1:0]  pwdata = '0;
   logic [N-1:0]  prdata;
   logic [N-1:0]  gpio_in = '0;
   logic [N-1:0]  gpio_out, gpio_oe;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   gpio_irq_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .gpio_in(gpio_in),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [N-1:0] m_out, m_dir, m_mode, m_pol, m_both, m_en, m_pend;
   logic [N-1:0] m_pipe [$];   // [0]=stage1 [1]=sync [2]=delayed

   function automatic logic [N-1:0] m_status();
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         if (!m_en[i]) r[i] = 1'b0;
         else if (m_mode[i]) r[i] = m_pend[i];
         else r[i] = (m_pipe[1][i] == m_pol[i]);
      end
      return r;
   endfunction

   function automatic logic [N-1:0] m_read(int k);
      case (k)
         0, 1:   return m_out;
         2, 3:   return m_dir;
         4, 5:   return m_mode;
         6, 7:   return m_pol;
         8, 9:   return m_both;
         10, 11: return m_en;
         12:     return m_status();
         13:     return m_pipe[1];
         default: return '0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_out = '0; m_dir = '0; m_mode = '0; m_pol = '1;
         m_both = '0; m_en = '0; m_pend = '0;
         m_pipe = '{'0, '0, '0};
      end else begin
         int k;
         bit wr;
         logic [N-1:0] nxt_pend;
         k  = int'(paddr[5:2]);
         wr = psel && penable && pwrite;
         for (int i = 0; i < N; i++) begin
            bit rise, fall, ev;
            rise = m_pipe[1][i] && !m_pipe[2][i];
            fall = !m_pipe[1][i] && m_pipe[2][i];
            ev = m_mode[i] && (m_both[i] ? (rise || fall) : (m_pol[i] ? rise : fall));
            nxt_pend[i] = ev || (m_pend[i] && !(wr && k == 12 && pwdata[i]));
         end
         m_pend = nxt_pend;
         if (wr) begin
            case (k)
               0:  m_out  = m_out  |  pwdata;  1: m_out  = m_out  & ~pwdata;
               2:  m_dir  = m_dir  |  pwdata;  3: m_dir  = m_dir  & ~pwdata;
               4:  m_mode = m_mode |  pwdata;  5: m_mode = m_mode & ~pwdata;
               6:  m_pol  = m_pol  |  pwdata;  7: m_pol  = m_pol  & ~pwdata;
               8:  m_both = m_both |  pwdata;  9: m_both = m_both & ~pwdata;
               10: m_en   = m_en   |  pwdata; 11: m_en   = m_en   & ~pwdata;
               default: ;
            endcase
         end
         m_pipe.push_front(gpio_in);
         void'(m_pipe.pop_back());
      end
   end

   task automatic chk(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string rd_tag(int k);
      if (k == 12) return "R8";
      if (k == 13) return "R3";
      if (k <= 1)  return "R2";
      if (k <= 3)  return "R1";
      if (k <= 9)  return "R5";
      return "R7";
   endfunction

   // every-cycle comparison against the model, away from the clock edge
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(gpio_out === m_out, "R2", gpio_out, m_out);
         chk(gpio_oe === m_dir, "R1", gpio_oe, m_dir);
         chk(irq === (m_status() != '0), "R7", N'(irq), N'(m_status() != '0));
         chk(prdata === m_read(int'(paddr[5:2])), rd_tag(int'(paddr[5:2])),
             prdata, m_read(int'(paddr[5:2])));
      end
   end

   // ---------------- bus tasks (called just after a falling edge) -------
   task automatic apb_wr(int k, logic [N-1:0] d);
      psel = 1; pwrite = 1; penable = 0; paddr = AW'(k << 2); pwdata = d;
      @(negedge clk);
      penable = 1;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0; pwdata = '0;
   endtask

   task automatic apb_rd(int k, output logic [N-1:0] d);
      paddr = AW'(k << 2); psel = 1; pwrite = 0;
      #1 d = prdata;
      psel = 0;
   endtask

   task automatic expect_reg(int k, logic [N-1:0] exp, string tag);
      logic [N-1:0] v;
      apb_rd(k, v);
      chk(v === exp, tag, v, exp);
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      settle(3);
      rst_n = 1;
      settle(1);
      // R10 reset state
      chk(gpio_oe === '0, "R10", gpio_oe, '0);
      chk(gpio_out === '0, "R10", gpio_out, '0);
      chk(N'(irq) === '0, "R10", N'(irq), '0);
      expect_reg(6, '1, "R10");
      expect_reg(4, '0, "R10");
      expect_reg(8, '0, "R10");

      // R1 direction
      apb_wr(2, 32'hFF);  chk(gpio_oe === 32'hFF, "R1", gpio_oe, 32'hFF);
      apb_wr(3, 32'h0F);  chk(gpio_oe === 32'hF0, "R1", gpio_oe, 32'hF0);
      // R2 output data, R11 zero bits
      apb_wr(0, 32'hA5);  chk(gpio_out === 32'hA5, "R2", gpio_out, 32'hA5);
      apb_wr(1, 32'h05);  chk(gpio_out === 32'hA0, "R2", gpio_out, 32'hA0);
      apb_wr(1, 32'h0);   chk(gpio_out === 32'hA0, "R11", gpio_out, 32'hA0);
      apb_wr(0, 32'h0);   chk(gpio_out === 32'hA0, "R11", gpio_out, 32'hA0);
      apb_wr(3, 32'h0);   chk(gpio_oe === 32'hF0, "R11", gpio_oe, 32'hF0);

      // R3 synchronizer latency
      gpio_in = 32'h100;
      expect_reg(13, 32'h0, "R3");
      settle(1); expect_reg(13, 32'h0, "R3");
      settle(1); expect_reg(13, 32'h100, "R3");
      gpio_in = '0;
      settle(4);

      // R4 level mode
      apb_wr(10, 32'hF);
      gpio_in = 32'h1;
      settle(3);
      expect_reg(12, 32'h1, "R4");
      chk(N'(irq) === N'(1), "R7", N'(irq), N'(1));
      apb_wr(12, 32'h1);  expect_reg(12, 32'h1, "R4");
      apb_wr(7, 32'h2);   expect_reg(12, 32'h3, "R4");
      gpio_in = '0;
      settle(3);          expect_reg(12, 32'h2, "R4");
      apb_wr(6, 32'h2);   expect_reg(12, 32'h0, "R4");

      // R5 / R6 edge modes
      apb_wr(4, 32'hF0);
      apb_wr(7, 32'h20);
      apb_wr(8, 32'h40);
      apb_wr(10, 32'hF0);
      gpio_in = 32'h70;
      settle(4);          expect_reg(12, 32'h50, "R5");
      gpio_in = '0;
      settle(4);          expect_reg(12, 32'h70, "R6");
      apb_wr(12, 32'h70); expect_reg(12, 32'h0, "R5");
      chk(N'(irq) === '0, "R5", N'(irq), '0);

      // R9 edge coinciding with clear
      gpio_in = 32'h10;
      settle(1);
      apb_wr(12, 32'h10);
      settle(2);          expect_reg(12, 32'h10, "R9");

      // R7 enable masking
      apb_wr(11, '1);
      chk(N'(irq) === '0, "R7", N'(irq), '0);
      expect_reg(12, 32'h0, "R8");
      apb_wr(10, 32'h10);
      chk(N'(irq) === N'(1), "R7", N'(irq), N'(1));
      expect_reg(12, 32'h10, "R8");
      apb_wr(12, 32'h10);
      chk(N'(irq) === '0, "R7", N'(irq), '0);

      settle(3);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule